// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a watchdog timer with a 12-bit down-counter. The counter advances on a slow tick enable, which stands in for a dedicated low-speed oscillator, through a prescaler that divides by a power of two from 4 to 256. Software controls the block only by writing magic values to a key register. One value starts the watchdog, another refreshes the counter from the reload register, and a third opens the divider and reload registers for writing. When the counter reaches zero the block raises a system reset request and records the cause in a sticky flag. This flag survives the system reset and is cleared only by power-on reset or by software.

Once started, nothing written to the block can stop it. The only way to stop it is a system reset. The watchdog can also start itself: a strap input sampled while system reset is held starts it with no software action. Divider and reload writes pass through a shadow stage. Their busy bits stay set for a fixed number of ticks, and the new value takes effect when the busy bit clears.

Top module: `keyed_watchdog`

## Requirements
- R1: After power-on reset, the divider code (address 1) reads 0 and the reload value (address 2) reads 0xFFF. The status word (address 3) reads 0, and the reset request is low.
- R2: Writes to address 1 or address 2 are accepted only after the unlock key 0x5555 has been written to the key register (address 0). Writes made while locked leave the read-back value unchanged.
- R3: Writing any key value other than 0x5555 to address 0 removes write access, including the refresh key 0xAAAA and the start key 0xCCCC.
- R4: Writing 0xCCCC to address 0 starts the watchdog and sets status bit 2. No later register write clears that bit; only a system reset does.
- R5: Writing 0xAAAA to address 0 loads the counter with the active reload value and restarts the prescaler phase, whether or not the watchdog is running.
- R6: Divider code c selects a divide ratio of 4·2^c for c from 0 to 6; code 7 also selects 256. After a refresh with reload value N, the watchdog times out after exactly N·ratio ticks.
- R7: One clock after a running counter holds zero, the reset request goes high. It stays high, even through a refresh key, until system reset.
- R8: Status bit 3 sets together with the reset request. It survives system reset. Writing a 1 to status bit 3 clears it, writing a 0 leaves it unchanged, and power-on reset clears it.
- R9: An accepted divider write sets status bit 0, and an accepted reload write sets status bit 1. Each bit clears after SYNC_TICKS ticks (default 3), and at that point the new value becomes the one in use.
- R10: If the strap input is high while system reset is held, the watchdog is running when reset releases.
- R11: While the watchdog is not running, ticks do not change the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; also clears the cause flag |
| rst_n | input | 1 | System reset, active low, synchronous |
| tick | input | 1 | One-clock enable pulse from the low-speed time base |
| hw_start | input | 1 | Start strap, sampled while reset is held |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 key, 1 divider, 2 reload, 3 status |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address, same map |
| rd_data | output | 16 | Read data, combinational |
| rst_req | output | 1 | System reset request |

## Verification
The timeout path is swept over every divider code, with reload values of 1 and 3. For each case the bench counts ticks until the request appears, so an off-by-one in the prescaler phase, a wrong clamp for code 7, or a stale divider all show up as a count mismatch. Key sequences are tried in several orders: locked, unlocked, unlocked then foreign key, and unlocked then refresh. These separate a missing lock from a lock that never drops. Strap start, refresh while stopped, and flag clearing by write and by power-on reset each test one reset path in isolation.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
    localparam logic [15:0] KEY_UNLOCK = 16'h5555;
    localparam logic [15:0] KEY_REFRESH = 16'hAAAA;
    localparam logic [15:0] KEY_START = 16'hCCCC;

    localparam logic [1:0] ADDR_KEY = 2'd0;
    localparam logic [1:0] ADDR_DIV = 2'd1;
    localparam logic [1:0] ADDR_RLD = 2'd2;
    localparam logic [1:0] ADDR_STAT = 2'd3;

    localparam int STAT_DIV_BUSY = 0;
    localparam int STAT_RLD_BUSY = 1;
    localparam int STAT_RUN = 2;
    localparam int STAT_CAUSE = 3;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_UNLOCK,
        CMD_REFRESH,
        CMD_START,
        CMD_FOREIGN
    } key_cmd_e;
endpackage

// File: rtl/kwdt_keydec.sv
module kwdt_keydec
    import kwdt_pkg::*;
(
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [15:0] wr_data,
    output key_cmd_e    cmd
);
    always_comb begin
        cmd = CMD_NONE;
        if (wr_en && wr_addr == ADDR_KEY) begin
            unique case (wr_data)
                KEY_UNLOCK:  cmd = CMD_UNLOCK;
                KEY_REFRESH: cmd = CMD_REFRESH;
                KEY_START:   cmd = CMD_START;
                default:     cmd = CMD_FOREIGN;
            endcase
        end
    end
endmodule

// File: rtl/kwdt_shadow.sv
module kwdt_shadow #(
    parameter int W = 12,
    parameter int SYNC_TICKS = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wr_ok,
    input  logic [W-1:0] wr_val,
    output logic [W-1:0] prog,
    output logic [W-1:0] active,
    output logic         busy
);
    localparam int SW = (SYNC_TICKS > 1) ? $clog2(SYNC_TICKS) : 1;

    typedef struct packed {
        logic [W-1:0]  prog;
        logic [W-1:0]  act;
        logic          busy;
        logic [SW-1:0] scnt;
    } shadow_t;

    shadow_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (sh_q.busy && tick) begin
            if (sh_q.scnt == SW'(SYNC_TICKS - 1)) begin
                sh_d.busy = 1'b0;
                sh_d.act = sh_q.prog;
                sh_d.scnt = '0;
            end else begin
                sh_d.scnt = sh_q.scnt + 1'b1;
            end
        end
        if (wr_ok) begin
            sh_d.prog = wr_val;
            sh_d.busy = 1'b1;
            sh_d.scnt = '0;
        end
        if (!rst_n) begin
            sh_d = '{prog: RST_VAL, act: RST_VAL, busy: 1'b0, scnt: '0};
        end
    end

    always_ff @(posedge clk) begin
        sh_q <= sh_d;
    end

    assign prog = sh_q.prog;
    assign active = sh_q.act;
    assign busy = sh_q.busy;
endmodule

// File: rtl/kwdt_prescaler.sv
module kwdt_prescaler #(
    parameter int CODE_W = 3,
    parameter int BASE_LOG = 2,
    parameter int MAX_SHIFT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              run,
    input  logic              restart,
    input  logic [CODE_W-1:0] code,
    output logic              stroke
);
    localparam int PW = BASE_LOG + MAX_SHIFT;

    typedef struct packed {
        logic [PW-1:0] phase;
    } pre_t;

    pre_t pre_d, pre_q;
    logic [PW-1:0] limit;

    always_comb begin
        int unsigned sh;
        sh = (int'(code) > MAX_SHIFT) ? MAX_SHIFT : int'(code);
        limit = PW'((1 << (BASE_LOG + sh)) - 1);
        stroke = run && tick && (pre_q.phase >= limit);
        pre_d = pre_q;
        if (run && tick) begin
            pre_d.phase = stroke ? '0 : pre_q.phase + 1'b1;
        end
        if (restart || !rst_n) begin
            pre_d.phase = '0;
        end
    end

    always_ff @(posedge clk) begin
        pre_q <= pre_d;
    end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import kwdt_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int CODE_W = 3,
    parameter int SYNC_TICKS = 3
) (
    input  logic        clk,
    input  logic        por_n,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        hw_start,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [15:0] wr_data,
    input  logic [1:0]  rd_addr,
    output logic [15:0] rd_data,
    output logic        rst_req
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             run;
        logic             unlock;
        logic             req;
        logic             cause;
    } wd_t;

    wd_t st_d, st_q;

    logic              sys_rst_n;
    key_cmd_e          cmd;
    logic              stroke;
    logic [CODE_W-1:0] div_prog, div_act;
    logic [CNT_W-1:0]  rld_prog, rld_act;
    logic              div_busy, rld_busy;
    logic [CNT_W-1:0]  cnt_q;
    logic              run_q, unlock_q, cause_q;

    assign sys_rst_n = rst_n & por_n;
    assign cnt_q = st_q.cnt;
    assign run_q = st_q.run;
    assign unlock_q = st_q.unlock;
    assign cause_q = st_q.cause;
    assign rst_req = st_q.req;

    kwdt_keydec u_keydec (
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .cmd    (cmd)
    );

    kwdt_shadow #(.W(CODE_W), .SYNC_TICKS(SYNC_TICKS), .RST_VAL('0)) u_div (
        .clk   (clk),
        .rst_n (sys_rst_n),
        .tick  (tick),
        .wr_ok (wr_en && wr_addr == ADDR_DIV && unlock_q),
        .wr_val(wr_data[CODE_W-1:0]),
        .prog  (div_prog),
        .active(div_act),
        .busy  (div_busy)
    );

    kwdt_shadow #(.W(CNT_W), .SYNC_TICKS(SYNC_TICKS), .RST_VAL('1)) u_rld (
        .clk   (clk),
        .rst_n (sys_rst_n),
        .tick  (tick),
        .wr_ok (wr_en && wr_addr == ADDR_RLD && unlock_q),
        .wr_val(wr_data[CNT_W-1:0]),
        .prog  (rld_prog),
        .active(rld_act),
        .busy  (rld_busy)
    );

    kwdt_prescaler #(.CODE_W(CODE_W)) u_pre (
        .clk    (clk),
        .rst_n  (sys_rst_n),
        .tick   (tick),
        .run    (run_q),
        .restart(cmd == CMD_REFRESH),
        .code   (div_act),
        .stroke (stroke)
    );

    always_comb begin
        logic expire;
        st_d = st_q;
        if (stroke && cnt_q != '0) begin
            st_d.cnt = cnt_q - CNT_W'(1);
        end
        unique case (cmd)
            CMD_UNLOCK:  st_d.unlock = 1'b1;
            CMD_REFRESH: begin
                st_d.unlock = 1'b0;
                st_d.cnt = rld_act;
            end
            CMD_START: begin
                st_d.unlock = 1'b0;
                st_d.run = 1'b1;
            end
            CMD_FOREIGN: st_d.unlock = 1'b0;
            default: ;
        endcase
        if (wr_en && wr_addr == ADDR_STAT && wr_data[STAT_CAUSE]) begin
            st_d.cause = 1'b0;
        end
        expire = run_q && cnt_q == '0;
        if (expire) begin
            st_d.req = 1'b1;
            st_d.cause = 1'b1;
        end
        if (!sys_rst_n) begin
            st_d = '{cnt: '1, run: hw_start, unlock: 1'b0, req: 1'b0,
                     cause: por_n ? cause_q : 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_comb begin
        unique case (rd_addr)
            ADDR_DIV: rd_data = 16'(div_prog);
            ADDR_RLD: rd_data = 16'(rld_prog);
            ADDR_STAT: begin
                rd_data = '0;
                rd_data[STAT_DIV_BUSY] = div_busy;
                rd_data[STAT_RLD_BUSY] = rld_busy;
                rd_data[STAT_RUN] = run_q;
                rd_data[STAT_CAUSE] = cause_q;
            end
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/kwdt_checker.sv
module kwdt_checker #(
    parameter int CNT_W = 12,
    parameter int CODE_W = 3
) (
    input logic              clk,
    input logic              por_n,
    input logic              rst_n,
    input logic              rst_req,
    input logic              run,
    input logic              cause,
    input logic              unlock,
    input logic [CNT_W-1:0]  cnt,
    input logic [CODE_W-1:0] div_prog,
    input logic              wr_en,
    input logic [1:0]        wr_addr,
    input logic [15:0]       wr_data
);
    assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        rst_req |=> rst_req);

    assert_req_on_zero_R7: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (run && cnt == '0) |=> rst_req);

    assert_run_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        run |=> run);

    assert_cause_with_req_R8: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        $rose(rst_req) |-> cause);

    assert_locked_div_R2: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (wr_en && wr_addr == 2'd1 && !unlock) |=> $stable(div_prog));

    assert_stopped_cnt_R11: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (!run && !(wr_en && wr_addr == 2'd0 && wr_data == 16'hAAAA)) |=> $stable(cnt));
endmodule

bind keyed_watchdog kwdt_checker #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_chk (
    .clk     (clk),
    .por_n   (por_n),
    .rst_n   (rst_n),
    .rst_req (rst_req),
    .run     (run_q),
    .cause   (cause_q),
    .unlock  (unlock_q),
    .cnt     (cnt_q),
    .div_prog(div_prog),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
);

// File: tb/tb_keyed_watchdog.sv
module tb_keyed_watchdog;
    localparam int SYNC = 3;

    logic        clk = 1'b0;
    logic        por_n = 1'b0, rst_n = 1'b0, tick = 1'b0, hw_start = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0, rd_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        rst_req;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    keyed_watchdog #(.SYNC_TICKS(SYNC)) dut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .tick(tick), .hw_start(hw_start),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .rst_req(rst_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        @(negedge clk);
        rd_addr = a;
        #1 v = rd_data;
    endtask

    task automatic tk();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tk();
    endtask

    task automatic sysrst(input bit strap);
        @(negedge clk); rst_n = 1'b0; hw_start = strap;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); hw_start = 1'b0;
    endtask

    task automatic cfg(input int code, input int val);
        wr(2'd0, 16'h5555);
        wr(2'd1, 16'(code));
        wr(2'd2, 16'(val));
        ticks(SYNC);
    endtask

    task automatic until_req(output int n);
        n = 0;
        while (!rst_req && n < 2000) begin
            tk();
            n++;
        end
    endtask

    function automatic int ratio(input int code);
        return 4 << ((code > 6) ? 6 : code);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int n;
        repeat (3) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd1, v); chk("R1 divider", v, 0);
        rd(2'd2, v); chk("R1 reload", v, 16'hFFF);
        rd(2'd3, v); chk("R1 status", v, 0);
        chk("R1 request", rst_req, 0);

        // R2 locked writes ignored, unlocked accepted
        wr(2'd1, 16'd5); wr(2'd2, 16'd7);
        rd(2'd1, v); chk("R2 locked divider", v, 0);
        rd(2'd2, v); chk("R2 locked reload", v, 16'hFFF);
        wr(2'd0, 16'h5555); wr(2'd1, 16'd6);
        rd(2'd1, v); chk("R2 unlocked divider", v, 6);
        wr(2'd2, 16'h123);
        rd(2'd2, v); chk("R2 unlocked reload", v, 16'h123);

        // R3 foreign key and refresh key drop access
        wr(2'd0, 16'h1234); wr(2'd1, 16'd2);
        rd(2'd1, v); chk("R3 foreign key", v, 6);
        wr(2'd0, 16'h5555); wr(2'd0, 16'hAAAA); wr(2'd1, 16'd3);
        rd(2'd1, v); chk("R3 refresh key", v, 6);

        // R9 busy bits
        sysrst(0);
        wr(2'd0, 16'h5555); wr(2'd1, 16'd5);
        rd(2'd3, v); chk("R9 div busy set", v[0], 1);
        ticks(SYNC - 1);
        rd(2'd3, v); chk("R9 div busy held", v[0], 1);
        tk();
        rd(2'd3, v); chk("R9 div busy clear", v[0], 0);
        wr(2'd2, 16'd9);
        rd(2'd3, v); chk("R9 rld busy set", v[1], 1);
        ticks(SYNC);
        rd(2'd3, v); chk("R9 rld busy clear", v[1], 0);

        // R11 and R5: refresh while stopped, ticks do nothing
        sysrst(0);
        cfg(0, 2);
        wr(2'd0, 16'hAAAA);
        ticks(40);
        chk("R11 no request while stopped", rst_req, 0);
        wr(2'd0, 16'hCCCC);
        until_req(n);
        chk("R5 timeout from refreshed value", n, 8);

        // R7 request holds
        ticks(5);
        chk("R7 request held", rst_req, 1);
        wr(2'd0, 16'hAAAA); tk();
        chk("R7 refresh does not clear", rst_req, 1);
        rd(2'd3, v); chk("R8 cause set", v[3], 1);

        sysrst(0);
        chk("R7 request cleared by reset", rst_req, 0);
        rd(2'd3, v); chk("R8 cause survives reset", v, 16'h8);
        wr(2'd3, 16'h0);
        rd(2'd3, v); chk("R8 write zero keeps cause", v, 16'h8);
        wr(2'd3, 16'h8);
        rd(2'd3, v); chk("R8 write one clears cause", v, 0);

        cfg(0, 1);
        wr(2'd0, 16'hCCCC); wr(2'd0, 16'hAAAA);
        until_req(n);
        chk("R6 reload one ratio four", n, 4);
        @(negedge clk); por_n = 1'b0; rst_n = 1'b0;
        repeat (2) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        rd(2'd3, v); chk("R8 power-on clears cause", v, 0);

        // R4 cannot be stopped
        sysrst(0);
        wr(2'd0, 16'hCCCC);
        rd(2'd3, v); chk("R4 started", v[2], 1);
        wr(2'd0, 16'h0000); wr(2'd0, 16'h5555); wr(2'd3, 16'h0); wr(2'd3, 16'hFFFF);
        rd(2'd3, v); chk("R4 still running", v[2], 1);

        // R10 strap start
        sysrst(1);
        rd(2'd3, v); chk("R10 strap running", v[2], 1);
        cfg(0, 1);
        wr(2'd0, 16'hAAAA);
        until_req(n);
        chk("R10 strap counts", n, 4);

        // R6 sweep of every divider code
        for (int c = 0; c < 8; c++) begin
            for (int r = 1; r <= 3; r += 2) begin
                sysrst(0);
                cfg(c, r);
                wr(2'd0, 16'hCCCC); wr(2'd0, 16'hAAAA);
                until_req(n);
                chk($sformatf("R6 code %0d reload %0d", c, r), n, r * ratio(c));
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule